// File: doc/BRIEF.md
# Clock Output Gate and Mode Bank

This block sits between the clock synthesizers and the output pads of a system clock generator. It takes twelve internally generated clocks and gives each one its own gate: a pair of processor clocks, a free-running bus clock and six slot bus clocks, an interrupt-controller clock, a selectable 24/48 MHz clock and a copy of the reference. Each gate passes its clock or holds it low, and it never cuts a high phase short. A separate pad enable goes with each gated clock.

A two-bit mode field applies to all outputs. It selects normal running, a bypass in which every output is fed from the reference input, spread-spectrum operation (signalled to downstream logic), or high impedance on every pad. The block also decides which frequency selection reaches the synthesizer: the external select pin or a register field.

Output index map used on all vector ports: 0 CPU0, 1 CPU1, 2 free-running bus clock, 3..8 bus clocks 1..6, 9 interrupt-controller clock, 10 24/48 MHz clock, 11 reference copy.

Top module: `clkgate_bank`

## Requirements
- R1: In normal mode (`ctl3[1:0]`=00), an output whose enable is 1 follows its own `src_clk` bit.
- R2: An output whose enable is 0 is driven low while its `clk_oe` bit stays 1.
- R3: While `rst_n` is low, every gate passes its clock whatever the enable bits hold, so all enables behave as reset to 1.
- R4: Enable bit positions: `ctl4` bit 0 CPU0, bit 2 CPU1, bit 6 the 24/48 clock; `ctl5` bits 0..3 bus clocks 1..4, bit 5 bus clock 5, bit 6 bus clock 6, bit 7 the free-running bus clock; `ctl6` bit 5 the interrupt-controller clock. All other bits have no effect on the outputs.
- R5: An enable change takes effect only while the affected source is low: disabling during a high phase lets that phase finish, and enabling during a high phase gives no output until the next rising edge of the source.
- R6: Changing one output's enable leaves every other output undisturbed.
- R7: Mode 01 feeds every enabled output from `ref_clk` and raises `pll_bypass`; `spread_on` is low.
- R8: Mode 10 raises `spread_on`, keeps `pll_bypass` low and leaves the outputs on their internal clocks.
- R9: Mode 11 drives every `clk_oe` bit low and both flags low, whatever the enables hold; in every other mode all `clk_oe` bits are 1.
- R10: With `ctl3[3]`=0, `freq_code` is {0,000,`ext_fsel`}; with `ctl3[3]`=1 it is {1,`ctl3[7:4]`} and `ext_fsel` has no effect.
- R11: The reference copy runs only when `ctl6` bits 1 and 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low system reset, forces gates open |
| ref_clk | input | 1 | Reference clock input, used in bypass mode |
| ext_fsel | input | 1 | External frequency select pin |
| src_clk | input | 12 | Internally generated clocks, index map above |
| ctl3 | input | 8 | Mode (1:0), frequency source (3), frequency field (7:4) |
| ctl4 | input | 8 | Processor and 24/48 clock enables |
| ctl5 | input | 8 | Bus clock enables |
| ctl6 | input | 8 | Interrupt-controller and reference-copy enables |
| clk_out | output | 12 | Gated clocks |
| clk_oe | output | 12 | Pad output enables, 1 drives the pad |
| spread_on | output | 1 | Spread modulation request to the synthesizer |
| pll_bypass | output | 1 | Synthesizer bypass flag |
| freq_code | output | 5 | Frequency selection handed to the synthesizer |

## Verification
On every reference edge the assertions confirm that no output is high while its selected source is low, that a disabled output whose source was low on the previous sample stays low, and that the pad enables, mode flags and frequency code match the mode and select fields. The exact moment a gate opens or closes relative to a high phase, the bit position of each enable, the reset behaviour and the bypass to the reference clock are shown only by the bench's directed scenarios, which watch whole clock waveforms at the ports.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

   localparam int NUM_OUT = 12;
   localparam int CTL_W   = 8;

   localparam int O_CPU0 = 0;
   localparam int O_CPU1 = 1;
   localparam int O_BUSF = 2;
   localparam int O_BUS1 = 3;
   localparam int O_BUS5 = 7;
   localparam int O_BUS6 = 8;
   localparam int O_APIC = 9;
   localparam int O_USB  = 10;
   localparam int O_REFC = 11;

   typedef enum logic [1:0] {
      MODE_RUN    = 2'b00,
      MODE_BYPASS = 2'b01,
      MODE_SPREAD = 2'b10,
      MODE_HIZ    = 2'b11
   } mode_e;

   // Gather the scattered enable bits into output index order.
   function automatic logic [NUM_OUT-1:0] enable_map(
      input logic [CTL_W-1:0] r4,
      input logic [CTL_W-1:0] r5,
      input logic [CTL_W-1:0] r6);
      logic [NUM_OUT-1:0] e;
      e[O_CPU0]         = r4[0];
      e[O_CPU1]         = r4[2];
      e[O_BUSF]         = r5[7];
      e[O_BUS1 +: 4]    = r5[3:0];
      e[O_BUS5]         = r5[5];
      e[O_BUS6]         = r5[6];
      e[O_APIC]         = r6[5];
      e[O_USB]          = r4[6];
      e[O_REFC]         = r6[1] & r6[0];
      return e;
   endfunction

endpackage

// File: rtl/clkgate_mode_dec.sv
module clkgate_mode_dec
   import clkgate_pkg::*;
#(
   parameter int FSEL_W = 4
) (
   input  logic [CTL_W-1:0] ctl_mode,
   input  logic             ext_fsel,
   output logic             bypass,
   output logic             spread,
   output logic             hiz,
   output logic [FSEL_W:0]  freq_code
);
   localparam int SRC_BIT = 3;

   mode_e mode;
   assign mode = mode_e'(ctl_mode[1:0]);

   always_comb begin
      bypass = 1'b0;
      spread = 1'b0;
      hiz    = 1'b0;
      unique case (mode)
         MODE_RUN:    ;
         MODE_BYPASS: bypass = 1'b1;
         MODE_SPREAD: spread = 1'b1;
         MODE_HIZ:    hiz    = 1'b1;
         default:     ;
      endcase
   end

   always_comb begin
      if (ctl_mode[SRC_BIT])
         freq_code = {1'b1, ctl_mode[CTL_W-1 -: FSEL_W]};
      else
         freq_code = {{FSEL_W{1'b0}}, ext_fsel};
   end

endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell #(
   parameter bit GATE_LATCH = 1'b1
) (
   input  logic rst_n,
   input  logic src_clk,
   input  logic ref_clk,
   input  logic bypass,
   input  logic hiz,
   input  logic en,
   output logic clk_o,
   output logic oe_o
);
   logic src;
   logic en_q;

   assign src = bypass ? ref_clk : src_clk;

   generate
      if (GATE_LATCH) begin : g_latch
         // Transparent while the source is low: the held value can only
         // change when the gated output is already low.
         always_latch begin
            if (!rst_n)
               en_q <= 1'b1;
            else if (!src)
               en_q <= en;
         end
      end else begin : g_flop
         always_ff @(negedge src or negedge rst_n) begin
            if (!rst_n)
               en_q <= 1'b1;
            else
               en_q <= en;
         end
      end
   endgenerate

   assign clk_o = src & en_q;
   assign oe_o  = ~hiz;

endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
   import clkgate_pkg::*;
#(
   parameter int FSEL_W     = 4,
   parameter bit GATE_LATCH = 1'b1
) (
   input  logic               rst_n,
   input  logic               ref_clk,
   input  logic               ext_fsel,
   input  logic [NUM_OUT-1:0] src_clk,
   input  logic [CTL_W-1:0]   ctl3,
   input  logic [CTL_W-1:0]   ctl4,
   input  logic [CTL_W-1:0]   ctl5,
   input  logic [CTL_W-1:0]   ctl6,
   output logic [NUM_OUT-1:0] clk_out,
   output logic [NUM_OUT-1:0] clk_oe,
   output logic               spread_on,
   output logic               pll_bypass,
   output logic [FSEL_W:0]    freq_code
);
   localparam int FIELD_LSB = CTL_W - FSEL_W;

   generate
      if (FSEL_W < 1 || FIELD_LSB < 4) begin : g_bad_fsel
         $error("FSEL_W must leave ctl3 bits 3:0 free");
      end
   endgenerate

   logic               bypass;
   logic               hiz;
   logic [NUM_OUT-1:0] en_vec;

   clkgate_mode_dec #(.FSEL_W(FSEL_W)) u_dec (
      .ctl_mode  (ctl3),
      .ext_fsel  (ext_fsel),
      .bypass    (bypass),
      .spread    (spread_on),
      .hiz       (hiz),
      .freq_code (freq_code)
   );

   assign pll_bypass = bypass;
   assign en_vec     = enable_map(ctl4, ctl5, ctl6);

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
         clkgate_cell #(.GATE_LATCH(GATE_LATCH)) u_cell (
            .rst_n   (rst_n),
            .src_clk (src_clk[i]),
            .ref_clk (ref_clk),
            .bypass  (bypass),
            .hiz     (hiz),
            .en      (en_vec[i]),
            .clk_o   (clk_out[i]),
            .oe_o    (clk_oe[i])
         );
      end
   endgenerate

   logic unused_rsvd;
   assign unused_rsvd = ^{ctl3[2], ctl3[FIELD_LSB-1:4], ctl4[7], ctl4[5:3],
                          ctl4[1], ctl5[4], ctl6[7:6], ctl6[4:2]};

endmodule

// File: rtl/clkgate_bank_chk.sv
module clkgate_bank_chk
   import clkgate_pkg::*;
#(
   parameter int FSEL_W     = 4,
   parameter bit GATE_LATCH = 1'b1
) (
   input logic               rst_n,
   input logic               ref_clk,
   input logic               ext_fsel,
   input logic [NUM_OUT-1:0] src_clk,
   input logic [CTL_W-1:0]   ctl3,
   input logic [CTL_W-1:0]   ctl4,
   input logic [CTL_W-1:0]   ctl5,
   input logic [CTL_W-1:0]   ctl6,
   input logic [NUM_OUT-1:0] clk_out,
   input logic [NUM_OUT-1:0] clk_oe,
   input logic               spread_on,
   input logic               pll_bypass,
   input logic [FSEL_W:0]    freq_code
);
   logic [NUM_OUT-1:0] want_on;
   logic               past_ok;

   assign want_on = enable_map(ctl4, ctl5, ctl6);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
         logic sel_src;
         assign sel_src = (ctl3[1:0] == 2'b01) ? ref_clk : src_clk[i];

         p_under_src_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
            !sel_src |-> !clk_out[i]);

         if (GATE_LATCH) begin : g_lat
            p_held_low_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
               (past_ok && $past(!want_on[i] && !sel_src) && !want_on[i]
                && $stable(ctl3[1:0])) |-> !clk_out[i]);
         end
      end
   endgenerate

   p_hiz_all_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (ctl3[1:0] == 2'b11) |-> (clk_oe == '0 && !spread_on && !pll_bypass));

   p_pads_on_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (ctl3[1:0] != 2'b11) |-> (&clk_oe));

   p_flag_excl_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $onehot0({spread_on, pll_bypass}));

   p_bypass_mode_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      pll_bypass |-> (ctl3[1:0] == 2'b01));

   p_pin_sel_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !ctl3[3] |-> (freq_code[FSEL_W:1] == '0 && freq_code[0] == ext_fsel));

   logic unused_chk;
   assign unused_chk = ^{ctl3[7:4], ctl3[2]};

endmodule

bind clkgate_bank clkgate_bank_chk #(.FSEL_W(FSEL_W), .GATE_LATCH(GATE_LATCH)) u_chk (
   .rst_n      (rst_n),
   .ref_clk    (ref_clk),
   .ext_fsel   (ext_fsel),
   .src_clk    (src_clk),
   .ctl3       (ctl3),
   .ctl4       (ctl4),
   .ctl5       (ctl5),
   .ctl6       (ctl6),
   .clk_out    (clk_out),
   .clk_oe     (clk_oe),
   .spread_on  (spread_on),
   .pll_bypass (pll_bypass),
   .freq_code  (freq_code)
);

// File: tb/clkgate_bank_test.sv
`timescale 1ns/10ps
module clkgate_bank_test;
   localparam int N = 12;

   logic         rst_n;
   logic         ref_clk;
   logic         ext_fsel;
   logic [N-1:0] src_clk;
   logic [7:0]   ctl3, ctl4, ctl5, ctl6;
   logic [N-1:0] clk_out;
   logic [N-1:0] clk_oe;
   logic         spread_on;
   logic         pll_bypass;
   logic [4:0]   freq_code;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   clkgate_bank uut (
      .rst_n(rst_n), .ref_clk(ref_clk), .ext_fsel(ext_fsel), .src_clk(src_clk),
      .ctl3(ctl3), .ctl4(ctl4), .ctl5(ctl5), .ctl6(ctl6),
      .clk_out(clk_out), .clk_oe(clk_oe), .spread_on(spread_on),
      .pll_bypass(pll_bypass), .freq_code(freq_code)
   );

   // 125 MHz reference: edges on whole nanoseconds.
   initial begin
      ref_clk = 1'b0;
      forever #4 ref_clk = ~ref_clk;
   end

   // Internal clocks: edges on half nanoseconds, never on a reference edge.
   generate
      for (genvar g = 0; g < N; g++) begin : g_src
         localparam int HALF = 3 + (g % 5);
         logic c;
         initial begin
            c = 1'b0;
            #0.5;
            forever #(HALF) c = ~c;
         end
         assign src_clk[g] = c;
      end
   endgenerate

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Watch one output over 24 ns at quiet instants.
   task automatic expect_follow(input int idx, input bit from_ref, input bit on,
                                input string req);
      int miss = 0;
      logic got = 1'b0;
      logic exp = 1'b0;
      @(posedge ref_clk);
      #0.25;
      for (int k = 0; k < 24; k++) begin
         exp = on ? (from_ref ? ref_clk : src_clk[idx]) : 1'b0;
         if (clk_out[idx] !== exp && miss == 0) got = clk_out[idx];
         if (clk_out[idx] !== exp) miss++;
         #1;
      end
      chk(miss == 0, req, $sformatf("output %0d waveform (first bad value)", idx),
          got, ~got);
   endtask

   task automatic expect_quiet(input logic [N-1:0] mask, input string req);
      logic [N-1:0] seen = '0;
      @(posedge ref_clk);
      #0.25;
      for (int k = 0; k < 24; k++) begin
         seen |= clk_out & mask;
         #1;
      end
      chk(seen == '0, req, "outputs that should stay low", seen, 0);
   endtask

   // Bench's own enable placement for a single output.
   task automatic only_enable(input int j);
      ctl4 = 8'h00; ctl5 = 8'h00; ctl6 = 8'h00;
      case (j)
         0:  ctl4[0] = 1'b1;
         1:  ctl4[2] = 1'b1;
         2:  ctl5[7] = 1'b1;
         3, 4, 5, 6: ctl5[j-3] = 1'b1;
         7:  ctl5[5] = 1'b1;
         8:  ctl5[6] = 1'b1;
         9:  ctl6[5] = 1'b1;
         10: ctl4[6] = 1'b1;
         default: ctl6[1:0] = 2'b11;
      endcase
   endtask

   task automatic all_on();
      ctl4 = 8'h45; ctl5 = 8'hEF; ctl6 = 8'h23;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      ctl3 = 8'h00; ctl4 = 8'h00; ctl5 = 8'h00; ctl6 = 8'h00; ext_fsel = 1'b0;
      #40.25;
      expect_follow(0, 0, 1, "R3");
      expect_follow(11, 0, 1, "R3");
      chk(clk_oe == '1, "R3", "pad enables in reset", clk_oe, 12'hFFF);
      rst_n = 1'b1;
      #30;
      expect_quiet('1, "R2");
      chk(clk_oe == '1, "R2", "pad enables with outputs off", clk_oe, 12'hFFF);
   endtask

   task automatic t_bitmap();
      for (int j = 0; j < N; j++) begin
         only_enable(j);
         #30;
         expect_follow(j, 0, 1, "R4");
         expect_quiet(~(12'd1 << j), "R4");
      end
      // Unused bits set alone move nothing.
      ctl4 = 8'hBA; ctl5 = 8'h10; ctl6 = 8'hDC;
      #30;
      expect_quiet('1, "R4");
      ctl4 = 8'h00; ctl5 = 8'h00; ctl6 = 8'h01;
      #30;
      expect_quiet('1, "R11");
      ctl6 = 8'h02;
      #30;
      expect_quiet('1, "R11");
   endtask

   task automatic t_all_on();
      all_on();
      #30;
      for (int j = 0; j < N; j += 3) expect_follow(j, 0, 1, "R1");
   endtask

   task automatic t_edge_timing();
      all_on();
      #30;
      @(posedge src_clk[0]);
      #0.25;
      ctl4[0] = 1'b0;
      #0.25;
      chk(clk_out[0] === 1'b1, "R5", "high phase kept after disable", clk_out[0], 1);
      @(negedge src_clk[0]);
      #0.25;
      chk(clk_out[0] === 1'b0, "R5", "low after source falls", clk_out[0], 0);
      @(posedge src_clk[0]);
      #0.25;
      chk(clk_out[0] === 1'b0, "R5", "no pulse once disabled", clk_out[0], 0);
      ctl4[0] = 1'b1;
      #0.25;
      chk(clk_out[0] === 1'b0, "R5", "no partial pulse on enable", clk_out[0], 0);
      @(posedge src_clk[0]);
      #0.25;
      chk(clk_out[0] === 1'b1, "R5", "runs from next rising edge", clk_out[0], 1);
      // Toggle a neighbour's enable while watching another output.
      fork
         expect_follow(1, 0, 1, "R6");
         begin
            #5.1 ctl4[0] = 1'b0;
            #7 ctl4[0] = 1'b1;
            #6 ctl5[7] = 1'b0;
         end
      join
      expect_follow(2, 0, 0, "R6");
      ctl5[7] = 1'b1;
   endtask

   task automatic t_bypass();
      all_on();
      ctl5[0] = 1'b0;
      ctl3 = 8'h01;
      #30;
      expect_follow(0, 1, 1, "R7");
      expect_follow(9, 1, 1, "R7");
      expect_follow(3, 1, 0, "R7");
      chk({pll_bypass, spread_on} == 2'b10, "R7", "flags {bypass,spread}",
          {pll_bypass, spread_on}, 2'b10);
   endtask

   task automatic t_spread();
      all_on();
      ctl3 = 8'h02;
      #30;
      expect_follow(4, 0, 1, "R8");
      chk({pll_bypass, spread_on} == 2'b01, "R8", "flags {bypass,spread}",
          {pll_bypass, spread_on}, 2'b01);
   endtask

   task automatic t_hiz();
      all_on();
      ctl3 = 8'h03;
      #30;
      chk(clk_oe == '0, "R9", "pad enables in high impedance", clk_oe, 0);
      chk({pll_bypass, spread_on} == 2'b00, "R9", "flags in high impedance",
          {pll_bypass, spread_on}, 0);
      ctl4 = 8'h00; ctl5 = 8'h00; ctl6 = 8'h00;
      #10;
      chk(clk_oe == '0, "R9", "pad enables with outputs disabled", clk_oe, 0);
      ctl3 = 8'h00;
      #10;
      chk(clk_oe == '1, "R9", "pad enables back in normal mode", clk_oe, 12'hFFF);
   endtask

   task automatic t_freq();
      ctl3 = 8'h00; ext_fsel = 1'b1;
      #2;
      chk(freq_code == 5'b00001, "R10", "pin select high", freq_code, 5'b00001);
      ext_fsel = 1'b0;
      #2;
      chk(freq_code == 5'b00000, "R10", "pin select low", freq_code, 0);
      ctl3 = 8'hA8;
      #2;
      chk(freq_code == 5'b11010, "R10", "register field", freq_code, 5'b11010);
      ext_fsel = 1'b1;
      #2;
      chk(freq_code == 5'b11010, "R10", "pin ignored", freq_code, 5'b11010);
      ctl3 = 8'h00;
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      t_reset();
      t_bitmap();
      t_all_on();
      t_edge_timing();
      t_bypass();
      t_spread();
      t_hiz();
      t_freq();
      done = 1'b1;
      finish_up();
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual running expected finished");
         finish_up();
      end
   end

endmodule